// File: doc/BRIEF.md
# Fractional Base-Unit PWM Generator

This block produces one pulse-width modulated output from a fixed reference clock. The clock does not drive a terminal-count divider. Instead, a 22-bit phase accumulator adds a fixed-point increment, called the base unit, on every clock cycle. The base unit has an 8-bit integer part and a 14-bit fraction. The accumulator wraps modulo 2^22, so the output frequency is roughly the reference frequency times the base unit divided by 256. For example, a 19.2 MHz reference with a base unit of 1/16 gives about 4.69 kHz, and a fraction field of 1 gives the slowest rate, about 4.6 Hz.

The top 8 bits of the accumulator form the phase. The output is high while the phase is below an 8-bit on-time value, so the duty cycle is on-time/256 in steps of about 0.39 %. Software writes the base unit, the on-time and an enable bit through a small write port. The base unit and on-time go to shadow registers first. They are copied into the working registers only at an accumulator wrap, or at any time while the block is disabled, so no period ever runs with mixed settings.

Top module: `pwm_frac_top`

## Requirements
- R1: After reset the output is low, the block is disabled and the accumulator, shadow and working registers are zero.
- R2: A write with select 0 loads the base unit from data bits 29:22 (integer part) and 21:8 (fraction); all other data bits are ignored. With a base unit B (in units of 2^-14) that divides 2^22, the output period is 2^22/B clock cycles.
- R3: A write with select 1 loads the on-time from data bits 7:0. The output is high exactly while the top 8 accumulator bits are less than the on-time, giving on-time × period/256 high cycles per period when the base divides 2^14.
- R4: Base-unit and on-time writes made while enabled take effect only at the first accumulator wrap after the write; the period in progress completes with the old values.
- R5: An on-time of 0 keeps the output low; an on-time of 255 keeps it high for all but the last 1/256 of each period.
- R6: A write with select 2 sets the enable from data bit 0. While disabled the output is low and the accumulator is held at zero, from the first cycle after the disabling write.
- R7: In the first cycle after an enabling write the accumulator is at phase 0, the working registers hold the latest shadow values and the output is high if the on-time is non-zero.
- R8: When the base does not divide 2^22, the accumulator keeps its residue across wraps (modulo 2^22 arithmetic), so the output matches an exact cycle model for any base and on-time sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the register port |
| wr_sel_i | input | 2 | Target: 0 base unit, 1 on-time, 2 enable |
| wr_data_i | input | 32 | Write data, fields as in R2, R3, R6 |
| pwm_o | output | 1 | PWM output |

## Verification
Assertions check on every cycle that the working registers do not change between wraps while the block is enabled, that the accumulator is zero after a disabled cycle, that a wrap leaves a residue smaller than the increment, and that the output stays low for a zero on-time or while disabled. Only the bench scenarios can show the actual period and high-time counts for given base units, that a mid-period on-time change leaves the current pulse width intact, and that long sequences of random writes and non-dividing fractional bases track an independent cycle model.

// File: rtl/pwm_frac_pkg.sv
package pwm_frac_pkg;
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_DUTY = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pwm_frac_regs.sv
module pwm_frac_regs
  import pwm_frac_pkg::*;
#(
  parameter int unsigned ACC_W  = 22,
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ACC_W-1:0]  base_wr_i,
  input  logic [DUTY_W-1:0] duty_wr_i,
  input  logic              en_wr_i,
  input  logic              wrap_i,
  output logic              en_o,
  output logic [ACC_W-1:0]  base_o,
  output logic [DUTY_W-1:0] duty_o
);
  logic [ACC_W-1:0]  base_sh_q, base_act_q;
  logic [DUTY_W-1:0] duty_sh_q, duty_act_q;
  logic              en_q;
  logic              load_act;

  // working copy follows shadow at wrap or while idle
  assign load_act = !en_q || wrap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_sh_q <= '0;
      duty_sh_q <= '0;
      en_q      <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_BASE: base_sh_q <= base_wr_i;
        SEL_DUTY: duty_sh_q <= duty_wr_i;
        SEL_CTRL: en_q      <= en_wr_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_act_q <= '0;
      duty_act_q <= '0;
    end else if (load_act) begin
      base_act_q <= base_sh_q;
      duty_act_q <= duty_sh_q;
    end
  end

  assign en_o   = en_q;
  assign base_o = base_act_q;
  assign duty_o = duty_act_q;

  assert_hold_between_wraps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && !wrap_i) |=> ($stable(base_o) && $stable(duty_o)));
endmodule

// File: rtl/pwm_frac_acc.sv
module pwm_frac_acc #(
  parameter int unsigned ACC_W   = 22,
  parameter int unsigned PHASE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [ACC_W-1:0]   inc_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               wrap_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, inc_i};
  assign wrap_o = en_i && sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum[ACC_W-1:0];
    else           acc_q <= '0;
  end

  assign phase_o = acc_q[ACC_W-1 -: PHASE_W];

  assert_idle_clears_acc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc_q == '0));

  assert_wrap_residue_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (acc_q < $past(inc_i)));
endmodule

// File: rtl/pwm_frac_cmp.sv
module pwm_frac_cmp #(
  parameter int unsigned DUTY_W = 8
) (
  input  logic              en_i,
  input  logic [DUTY_W-1:0] phase_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  assign pwm_o = en_i && (phase_i < duty_i);
endmodule

// File: rtl/pwm_frac_top.sv
module pwm_frac_top
  import pwm_frac_pkg::*;
#(
  parameter int unsigned INT_W    = 8,
  parameter int unsigned FRAC_W   = 14,
  parameter int unsigned DUTY_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BASE_LSB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pwm_o
);
  localparam int unsigned ACC_W = INT_W + FRAC_W;
  localparam int unsigned TOP_B = BASE_LSB + ACC_W;

  logic              en;
  logic              wrap;
  logic [ACC_W-1:0]  base_act;
  logic [DUTY_W-1:0] duty_act;
  logic [DUTY_W-1:0] phase;
  logic              unused_hi_bits;

  assign unused_hi_bits = ^wr_data_i[DATA_W-1:TOP_B];

  pwm_frac_regs #(.ACC_W(ACC_W), .DUTY_W(DUTY_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .base_wr_i (wr_data_i[BASE_LSB +: ACC_W]),
    .duty_wr_i (wr_data_i[DUTY_W-1:0]),
    .en_wr_i   (wr_data_i[0]),
    .wrap_i    (wrap),
    .en_o      (en),
    .base_o    (base_act),
    .duty_o    (duty_act)
  );

  pwm_frac_acc #(.ACC_W(ACC_W), .PHASE_W(DUTY_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .inc_i   (base_act),
    .phase_o (phase),
    .wrap_o  (wrap)
  );

  pwm_frac_cmp #(.DUTY_W(DUTY_W)) u_cmp (
    .en_i    (en),
    .phase_i (phase),
    .duty_i  (duty_act),
    .pwm_o   (pwm_o)
  );

  assert_zero_duty_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_act == '0) |-> !pwm_o);

  assert_disabled_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !pwm_o);
endmodule

// File: tb/pwm_frac_top_tb_top.sv
module pwm_frac_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        pwm;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_frac_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .pwm_o(pwm)
  );

  // independent cycle model built from the requirements
  logic [21:0] m_acc, m_base, m_base_sh;
  logic [7:0]  m_duty, m_duty_sh;
  logic        m_en;
  logic [22:0] m_sum;
  logic        m_wrap;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = '0; m_base = '0; m_base_sh = '0;
      m_duty = '0; m_duty_sh = '0; m_en = 1'b0;
    end else begin
      m_sum  = {1'b0, m_acc} + {1'b0, m_base};
      m_wrap = m_en && m_sum[22];
      if (!m_en || m_wrap) begin
        m_base = m_base_sh;
        m_duty = m_duty_sh;
      end
      m_acc = m_en ? m_sum[21:0] : 22'd0;
      if (wr_en) begin
        if (wr_sel == 2'd0) m_base_sh = wr_data[29:8];
        else if (wr_sel == 2'd1) m_duty_sh = wr_data[7:0];
        else if (wr_sel == 2'd2) m_en = wr_data[0];
      end
    end
  end

  function automatic logic exp_pwm(logic en, logic [21:0] acc, logic [7:0] duty);
    return en && (acc[21:14] < duty);
  endfunction

  function automatic int exp_high(int per, int duty);
    return per * duty / 256;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) chk("R8 cycle model", int'(pwm), int'(exp_pwm(m_en, m_acc, m_duty)));
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(output int hi, output int per);
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!prev && pwm) break;
      prev = pwm;
    end
    hi = 0; per = 0;
    forever begin
      hi += int'(pwm); per++;
      prev = pwm;
      @(negedge clk);
      if (!prev && pwm) break;
    end
  endtask

  initial begin
    int hi, per, low_seen;
    repeat (3) @(negedge clk);
    chk("R1 reset output", int'(pwm), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle after reset", int'(pwm), 0);

    // R2/R3: integer base 1.0, on-time 64; garbage in unused bits
    wr(2'd0, 32'hC000_00FF | (32'd1 << 22));
    wr(2'd1, 32'hFFFF_FF40);
    wr(2'd2, 32'd1);
    chk("R7 high right after enable", int'(pwm), 1);
    measure(hi, per);
    chk("R2 period base 1.0", per, 256);
    chk("R3 high time duty 64", hi, exp_high(256, 64));

    // R4: change on-time mid-period
    measure(hi, per);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'd200;
    hi = 1;
    @(negedge clk);
    wr_en = 1'b0;
    hi += int'(pwm);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!pwm) break;
      hi++;
    end
    chk("R4 current pulse keeps old on-time", hi, 64);
    measure(hi, per);
    chk("R4 next period uses new on-time", hi, 200);

    // R2: fractional base 1/16
    wr(2'd0, 32'h400 << 8);
    wr(2'd1, 32'd128);
    measure(hi, per);
    measure(hi, per);
    chk("R2 period base 0.0625", per, 4096);
    chk("R3 high time base 0.0625", hi, exp_high(4096, 128));

    // R5: on-time 255 and 0 with base 1.0
    wr(2'd0, 32'd1 << 22);
    wr(2'd1, 32'd255);
    measure(hi, per);
    measure(hi, per);
    chk("R5 on-time 255 high", hi, 255);
    chk("R5 on-time 255 period", per, 256);
    wr(2'd1, 32'd0);
    repeat (300) @(negedge clk);
    low_seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      low_seen += int'(!pwm);
    end
    chk("R5 on-time 0 stays low", low_seen, 300);

    // R6/R7: disable then re-enable
    wr(2'd1, 32'd100);
    repeat (40) @(negedge clk);
    wr(2'd2, 32'd0);
    chk("R6 low after disable", int'(pwm), 0);
    low_seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      low_seen += int'(!pwm);
    end
    chk("R6 stays low while disabled", low_seen, 50);
    wr(2'd2, 32'd1);
    chk("R7 restart at phase 0", int'(pwm), 1);
    measure(hi, per);
    chk("R7 period after restart", per, 256);

    // R2: slow fraction-only base (2^-6)
    wr(2'd0, 32'h100 << 8);
    wr(2'd1, 32'd1);
    measure(hi, per);
    measure(hi, per);
    chk("R2 period fraction-only base", per, 16384);
    chk("R3 high time fraction-only base", hi, 64);

    // R8: random bases, on-times and enables against the model
    void'($urandom(32'd7));
    for (int k = 0; k < 60; k++) begin
      int sel;
      logic [31:0] d;
      sel = $urandom_range(0, 9);
      d = $urandom;
      if (sel < 5) begin
        d[29:22] = 8'($urandom_range(1, 15));
        wr(2'd0, d);
      end else if (sel < 9) begin
        wr(2'd1, d);
      end else begin
        wr(2'd2, {31'd0, 1'b1});
      end
      repeat ($urandom_range(20, 400)) @(negedge clk);
    end
    wr(2'd3, 32'hFFFF_FFFF);
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule